// File: doc/BRIEF.md
# Interrupt redirection controller

This block routes up to sixteen level-sensitive interrupt inputs to a set of CPUs. Software reaches its internal registers only indirectly. A 32-bit bus exposes two words: a select register and a data window. The low byte of the select register picks which internal register the window reads or writes.

Each input owns a 64-bit redirection entry. The entry holds a vector, a destination CPU number, a mask bit, a trigger-mode bit and the mode fields. When an input's recorded level goes from low to high and its entry allows delivery, the block emits one message. The message carries the vector and a one-hot CPU mask, or every active CPU when the destination is 0xFF, and it leaves through a valid/ready port.

A masked level-triggered input that asserts is remembered as pending. It is replayed when software unmasks the entry, provided the input is still high at that moment.

Top module: `irq_router`

## Requirements
- R1: Only 32-bit accesses (`bus_word`=1) to offset 0x00 (select) or 0x10 (window) are decoded. Any other access reads as 0 and its write changes nothing.
- R2: The select register holds all 32 written bits and reads them back at offset 0x00. Window accesses use only bits 7:0 of it as the register index.
- R3: Index 0 is the identity register and keeps only bits 27:24 of a write. Index 2 reads the same value. Writes to index 1 or index 2 change nothing.
- R4: Index 1 reads the constant (NPIN << 16) | 0x11, which is 0x00100011 for 16 inputs.
- R5: Entry n is read and written as two independent 32-bit halves: the low half at index 0x10+2n and the high half at 0x11+2n. After reset both halves of every entry read 0x00010000. An index that maps to no register reads 0.
- R6: A message is produced only when an input's recorded state goes from low to high. An input that stays high, or that falls, produces nothing.
- R7: On such a rise, delivery requires low-half bit 16 (mask) = 0, bit 11 (destination mode) = 0 and bits 10:8 (delivery mode) = 000. The message vector is low-half bits 7:0, and the destination number is high-half bits 31:24.
- R8: Destination 0xFF sends `msg_dest` = `cpu_active`. A destination below NCPU sends a mask with only that bit set. Any other destination, or an empty active set on broadcast, sends no message.
- R9: A rise while bit 16 and bit 15 (level) are both set marks the input pending. A low-half write with bit 16 = 0 to a pending entry clears the mark. It delivers the interrupt only if the input is still recorded high; otherwise the interrupt is dropped.
- R10: `msg_valid` stays high with a stable vector and mask until `msg_ready` accepts it. When several inputs wait at once, the lowest-numbered input is sent first, and the others are held until each is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = access is 32 bits wide |
| bus_addr | input | AW | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| pin_in | input | NPIN | Interrupt input levels |
| cpu_active | input | NCPU | CPUs that receive a broadcast |
| msg_valid | output | 1 | Message available |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | NCPU | One-hot or broadcast CPU mask |
| msg_ready | input | 1 | Downstream accepts the message |

## Verification
The bench keeps NPIN at 16 so the full table, the version constant and the index past the last entry (0x30) are all exercised. It narrows NCPU to 4, which makes a plain destination number such as 5 fall outside the CPU range and brings the dropped-unicast path within reach without a large mask. With four CPUs, a partial active set such as 1011 also shows whether a broadcast copies the active mask rather than all ones.

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router #(
  parameter int NPIN = 16,
  parameter int NCPU = 8,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_wr,
  input  logic            bus_word,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NCPU-1:0] cpu_active,
  output logic            msg_valid,
  output logic [7:0]      msg_vector,
  output logic [NCPU-1:0] msg_dest,
  input  logic            msg_ready
);
  localparam int PW = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam int TBL_END = 16 + 2 * NPIN;
  localparam logic [31:0] VER_VAL = (32'(NPIN) << 16) | 32'h11;
  localparam logic [31:0] ENTRY_RST = 32'h0001_0000;

  logic [31:0]     sel_q;
  logic [3:0]      id_q;
  logic [31:0]     lo_q [NPIN];
  logic [31:0]     hi_q [NPIN];
  logic [NPIN-1:0] pin_q, pend_q, fire_q;

  function automatic logic can_go(input logic [31:0] lo);
    return !lo[16] && !lo[11] && (lo[10:8] == 3'b000);
  endfunction

  wire hit_sel = bus_en && bus_word && (bus_addr == AW'(0));
  wire hit_win = bus_en && bus_word && (bus_addr == AW'(16));
  wire [7:0] widx = sel_q[7:0];
  wire in_tbl = (widx >= 8'h10) && (32'(widx) < TBL_END);
  wire [7:0] toff = widx - 8'h10;
  wire [6:0] ent = toff[7:1];
  wire half = toff[0];
  wire [PW-1:0] ent_i = ent[PW-1:0];
  wire tbl_wr = hit_win && bus_wr && in_tbl;
  wire [NPIN-1:0] rise = pin_in & ~pin_q;

  logic [31:0] win_rd;
  always_comb begin
    case (widx)
      8'h00, 8'h02: win_rd = {4'b0, id_q, 24'b0};
      8'h01:        win_rd = VER_VAL;
      default:      win_rd = in_tbl ? (half ? hi_q[ent_i] : lo_q[ent_i]) : 32'b0;
    endcase
  end

  assign bus_rdata = (!bus_en || bus_wr) ? 32'b0 :
                     hit_sel ? sel_q : hit_win ? win_rd : 32'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (hit_sel && bus_wr) sel_q <= bus_wdata;
      if (hit_win && bus_wr && widx == 8'h00) id_q <= bus_wdata[27:24];
    end
  end

  logic [PW-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (fire_q[i]) pick = PW'(i);
  end

  wire can_load = !msg_valid || msg_ready;
  wire take = can_load && (|fire_q);
  wire [7:0] did = hi_q[pick][31:24];
  wire [NCPU-1:0] dmask = (did == 8'hFF) ? cpu_active :
                          (32'(did) < NCPU) ? (NCPU'(1) << did) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIN; i++) begin
        lo_q[i] <= ENTRY_RST;
        hi_q[i] <= ENTRY_RST;
      end
      pin_q  <= '0;
      pend_q <= '0;
      fire_q <= '0;
    end else begin
      pin_q <= pin_in;
      for (int i = 0; i < NPIN; i++) begin
        logic lo_w, unmask, setf;
        lo_w   = tbl_wr && (ent == 7'(i)) && !half;
        unmask = lo_w && pend_q[i] && !bus_wdata[16];
        setf   = (rise[i] && can_go(lo_q[i])) ||
                 (unmask && pin_q[i] && can_go(bus_wdata));
        if (lo_w) lo_q[i] <= bus_wdata;
        if (tbl_wr && (ent == 7'(i)) && half) hi_q[i] <= bus_wdata;
        if (unmask) pend_q[i] <= 1'b0;
        else if (rise[i] && lo_q[i][16] && lo_q[i][15]) pend_q[i] <= 1'b1;
        if (setf) fire_q[i] <= 1'b1;
        else if (take && pick == PW'(i)) fire_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_dest   <= '0;
    end else if (can_load) begin
      msg_valid <= take && (dmask != '0);
      if (take) begin
        msg_vector <= lo_q[pick][7:0];
        msg_dest   <= dmask;
      end
    end
  end

  // R10
  msg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));

  // R8
  dest_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_dest != '0);

  // R1
  stray_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_wr && !hit_sel && !hit_win |-> bus_rdata == 32'b0);

  // R6
  fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|fire_q) |-> $past(|rise) || $past(tbl_wr));

  for (genvar g = 0; g < NPIN; g++) begin : g_chk
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_wr && !half && ent == 7'(g) && !bus_wdata[16] |=> !pend_q[g]);
  end
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int NPIN = 16;
  localparam int NCPU = 4;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_wr = 0, bus_word = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NCPU-1:0] cpu_active = 4'b1111;
  logic msg_valid, msg_ready = 1;
  logic [7:0] msg_vector;
  logic [NCPU-1:0] msg_dest;

  int compared = 0, mismatched = 0;
  logic [8+NCPU-1:0] exp_q[$];

  irq_router #(.NPIN(NPIN), .NCPU(NCPU), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .cpu_active(cpu_active), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_ready(msg_ready));

  always #2 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", r, got, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n && msg_valid && msg_ready) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R6 unexpected message actual=%h/%b expected=none", msg_vector, msg_dest);
      end else begin
        logic [8+NCPU-1:0] e;
        e = exp_q.pop_front();
        if ({msg_vector, msg_dest} !== e) begin
          mismatched++;
          $display("FAIL R7 message actual=%h expected=%h", {msg_vector, msg_dest}, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [31:0] d, input logic w = 1'b1);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_word = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic br(input logic [AW-1:0] a, output logic [31:0] d, input logic w = 1'b1);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_word = w; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic ww(input logic [7:0] idx, input logic [31:0] d);
    bw(12'h000, {24'b0, idx});
    bw(12'h010, d);
  endtask

  task automatic wr_rd(input logic [7:0] idx, output logic [31:0] d);
    bw(12'h000, {24'b0, idx});
    br(12'h010, d);
  endtask

  task automatic expect_msg(input logic [7:0] v, input logic [NCPU-1:0] m);
    exp_q.push_back({v, m});
  endtask

  task automatic pin(input int p, input logic lvl);
    @(negedge clk);
    pin_in[p] = lvl;
  endtask

  task automatic drained(input string r);
    idle(6);
    chk(r, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1;
    idle(2);
    chk("R10 reset valid", {31'b0, msg_valid}, 32'd0);
    wr_rd(8'h01, d); chk("R4 version", d, 32'h0010_0011);
    wr_rd(8'h1A, d); chk("R5 reset lo", d, 32'h0001_0000);
    wr_rd(8'h1B, d); chk("R5 reset hi", d, 32'h0001_0000);

    bw(12'h000, 32'hABCD_1234);
    br(12'h000, d); chk("R2 select readback", d, 32'hABCD_1234);
    bw(12'h000, 32'h1234_5601);
    br(12'h010, d); chk("R2 low byte index", d, 32'h0010_0011);

    ww(8'h00, 32'hFFFF_FFFF);
    wr_rd(8'h00, d); chk("R3 id bits", d, 32'h0F00_0000);
    wr_rd(8'h02, d); chk("R3 arb mirrors id", d, 32'h0F00_0000);
    ww(8'h01, 32'h0);
    wr_rd(8'h01, d); chk("R3 version write ignored", d, 32'h0010_0011);
    ww(8'h02, 32'h0);
    wr_rd(8'h00, d); chk("R3 arb write ignored", d, 32'h0F00_0000);

    bw(12'h000, 32'h0000_0055);
    bw(12'h008, 32'h0000_0077);
    br(12'h000, d); chk("R1 stray write ignored", d, 32'h0000_0055);
    br(12'h004, d); chk("R1 stray read zero", d, 32'h0);
    bw(12'h000, 32'h0000_0066, 1'b0);
    br(12'h000, d); chk("R1 narrow write ignored", d, 32'h0000_0055);
    br(12'h000, d, 1'b0); chk("R1 narrow read zero", d, 32'h0);

    ww(8'h2F, 32'hDEAD_BEEF);
    wr_rd(8'h2F, d); chk("R5 hi write", d, 32'hDEAD_BEEF);
    wr_rd(8'h2E, d); chk("R5 lo untouched", d, 32'h0001_0000);
    wr_rd(8'h30, d); chk("R5 unmapped index", d, 32'h0);

    ww(8'h14, 32'h0000_0041); ww(8'h15, 32'h0200_0000);
    expect_msg(8'h41, 4'b0100);
    pin(2, 1); drained("R7 unicast delivered");
    idle(4); drained("R6 held high silent");
    pin(2, 0); drained("R6 fall silent");
    expect_msg(8'h41, 4'b0100);
    pin(2, 1); drained("R6 second rise");

    ww(8'h16, 32'h0001_0042); ww(8'h17, 32'h0);
    pin(3, 1); drained("R7 masked silent");
    ww(8'h18, 32'h0000_0843); ww(8'h19, 32'h0);
    pin(4, 1); drained("R7 logical mode silent");
    ww(8'h1A, 32'h0000_0144); ww(8'h1B, 32'h0);
    pin(5, 1); drained("R7 non-fixed silent");

    cpu_active = 4'b1011;
    ww(8'h1C, 32'h0000_0050); ww(8'h1D, 32'hFF00_0000);
    expect_msg(8'h50, 4'b1011);
    pin(6, 1); drained("R8 broadcast");
    ww(8'h1E, 32'h0000_0051); ww(8'h1F, 32'h0500_0000);
    pin(7, 1); drained("R8 out-of-range dropped");

    ww(8'h20, 32'h0001_8060); ww(8'h21, 32'h0100_0000);
    pin(8, 1); drained("R9 masked level silent");
    expect_msg(8'h60, 4'b0010);
    ww(8'h20, 32'h0000_8060); drained("R9 replay on unmask");
    ww(8'h20, 32'h0001_8060);
    ww(8'h20, 32'h0000_8060); drained("R9 pending cleared");
    ww(8'h20, 32'h0001_8060);
    pin(8, 0); pin(8, 1); pin(8, 0);
    ww(8'h20, 32'h0000_8060); drained("R9 dropped when low");
    ww(8'h22, 32'h0001_0061); ww(8'h23, 32'h0);
    pin(9, 1);
    ww(8'h22, 32'h0000_0061); drained("R9 edge not pending");

    @(negedge clk); msg_ready = 0;
    ww(8'h24, 32'h0000_0070); ww(8'h25, 32'h0);
    ww(8'h28, 32'h0000_0072); ww(8'h29, 32'h0300_0000);
    expect_msg(8'h70, 4'b0001);
    expect_msg(8'h72, 4'b1000);
    @(negedge clk); pin_in[10] = 1; pin_in[12] = 1;
    idle(5);
    #1;
    chk("R10 held valid", {31'b0, msg_valid}, 32'd1);
    chk("R10 lowest first", {24'b0, msg_vector}, 32'h70);
    @(negedge clk); msg_ready = 1;
    drained("R10 both delivered");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule